// File: doc/BRIEF.md
# Dual-Priority Memory Operation Engine

This block runs byte-serial operations on a shared single-port on-chip RAM on behalf of a command decoder. Each command names one of four operations: append a RAM block to a transmit buffer, forward copy, copy with the byte order reversed, or XOR a source block into a destination block in place. Every command also carries a priority bit. The engine holds one context per priority level, so one low and one high operation may be pending together.

The RAM has a read latency of one cycle. The engine takes the RAM port one byte at a time. At each byte boundary the high slot wins the port, and a paused low operation picks up at the byte where it stopped. Results are reported as one-cycle exception pulses. A done pulse per level fires on every completion, including a failed one. Separate pulses flag a rejected command, an out-of-range address and a full transmit buffer. The top-level command inputs and the exception outputs are the only software-visible interface here.

Top module: `mem_op_engine`

## Requirements
- R1: A command with `cmd_prio`=0 occupies the low slot and ends with a pulse on `exc_done_lo`. With `cmd_prio`=1 it occupies the high slot and ends with a pulse on `exc_done_hi`.
- R2: Opcode 1 (forward copy) writes the byte at RAM[src+n] to RAM[dst+n] for n = 0..count-1.
- R3: Opcode 2 (reverse copy) writes the byte at RAM[src+n] to RAM[dst+count-1-n].
- R4: Opcode 3 (XOR) writes RAM[src+n] XOR RAM[dst+n] back to RAM[dst+n].
- R5: Opcode 0 (transmit append) presents the bytes RAM[src..src+count-1] in order on `txb_wdata`, one per `txb_we` pulse. The destination field is ignored.
- R6: If `txb_level` equals `TXB_DEPTH` when a transmit byte would start, no further byte is pushed. `exc_tx_ovf` pulses, and `tx_remain` then holds the count of bytes not moved. `tx_remain` changes at no other time.
- R7: Every completion pulses the done output of its own level, whether the command succeeded or failed. The done pulse comes one cycle after the final write, or one cycle after the command for an immediate outcome.
- R8: A command for a level whose slot is busy is rejected with an `exc_usage` pulse one cycle later. The running operation is not disturbed, and the rejected command touches no memory.
- R9: If src+count exceeds 4096, or dst+count exceeds 4096 for opcodes 1 to 3, then `exc_addr_err` and the level's done pulse fire one cycle after the command. No RAM access is made. A range that ends exactly at 4096 is legal.
- R10: While both slots are pending, high-slot bytes take the RAM port. The low operation resumes afterwards and still produces a correct result.
- R11: A count of zero produces the level's done pulse one cycle after the command, with no RAM or buffer access.
- R12: While reset is held, all exception outputs, `ram_en`, `txb_we` and `tx_remain` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Operation: 0 append, 1 copy, 2 reverse copy, 3 XOR |
| cmd_prio | input | 1 | Priority level: 0 low, 1 high |
| cmd_count | input | 8 | Byte count |
| cmd_src | input | 12 | Source start address |
| cmd_dst | input | 12 | Destination start address |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable (read when low) |
| ram_addr | output | 12 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after a read |
| txb_we | output | 1 | Transmit buffer push |
| txb_wdata | output | 8 | Transmit buffer data |
| txb_level | input | 8 | Current transmit buffer fill level |
| exc_done_lo | output | 1 | Low-level completion pulse |
| exc_done_hi | output | 1 | High-level completion pulse |
| exc_usage | output | 1 | Command rejected, slot busy |
| exc_addr_err | output | 1 | Address range beyond memory |
| exc_tx_ovf | output | 1 | Transmit buffer full during append |
| tx_remain | output | 8 | Bytes not moved by the last overflowed append |

## Verification
A corrupt byte index or slot context shows up as wrong destination bytes or a wrong order on the buffer port. The whole memory is compared against a bench reference as soon as each done pulse arrives. A slot that fails to clear or to hold its state shows one cycle after the next command, as a spurious or missing usage or done pulse. The scoreboard checks the exact sequence of pulses, so broken arbitration shows as done events arriving in the wrong order. A bad overflow count is visible on `tx_remain` in the cycle after the overflow pulse.

// File: rtl/mope_pkg.sv
package mope_pkg;
   typedef enum logic [1:0] {
      OP_TXAPP   = 2'd0,
      OP_COPY    = 2'd1,
      OP_REVCOPY = 2'd2,
      OP_XOR     = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      PH_START  = 2'd0,
      PH_SECOND = 2'd1,
      PH_THIRD  = 2'd2
   } phase_e;
endpackage

// File: rtl/mope_range_chk.sv
module mope_range_chk #(
   parameter int AW = 12,
   parameter int CW = 8
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] len,
   output logic          over
);
   localparam logic [AW:0] LIMIT = (AW+1)'(1) << AW;
   assign over = ({1'b0, base} + (AW+1)'(len)) > LIMIT;
endmodule

// File: rtl/mope_slot.sv
module mope_slot
   import mope_pkg::*;
#(
   parameter int AW = 12,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  op_e           load_op,
   input  logic [CW-1:0] load_cnt,
   input  logic [AW-1:0] load_src,
   input  logic [AW-1:0] load_dst,
   input  logic          adv,
   input  logic          fin,
   output logic          active,
   output op_e           op,
   output logic [CW-1:0] cnt,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [CW-1:0] idx
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         op     <= OP_TXAPP;
         cnt    <= '0;
         src    <= '0;
         dst    <= '0;
         idx    <= '0;
      end else if (load) begin
         active <= 1'b1;
         op     <= load_op;
         cnt    <= load_cnt;
         src    <= load_src;
         dst    <= load_dst;
         idx    <= '0;
      end else begin
         if (fin) active <= 1'b0;
         if (adv) idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/mem_op_engine.sv
module mem_op_engine
   import mope_pkg::*;
#(
   parameter int AW        = 12,
   parameter int CW        = 8,
   parameter int DW        = 8,
   parameter int LW        = 8,
   parameter int TXB_DEPTH = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic          cmd_prio,
   input  logic [CW-1:0] cmd_count,
   input  logic [AW-1:0] cmd_src,
   input  logic [AW-1:0] cmd_dst,
   output logic          ram_en,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   input  logic [DW-1:0] ram_rdata,
   output logic          txb_we,
   output logic [DW-1:0] txb_wdata,
   input  logic [LW-1:0] txb_level,
   output logic          exc_done_lo,
   output logic          exc_done_hi,
   output logic          exc_usage,
   output logic          exc_addr_err,
   output logic          exc_tx_ovf,
   output logic [CW-1:0] tx_remain
);
   localparam int NSLOT = 2;
   localparam logic [LW-1:0] FULL_LVL = LW'(TXB_DEPTH);

   generate
      if (CW > AW) begin : g_bad_cw
         $error("count width must not exceed address width");
      end
      if (TXB_DEPTH >= (1 << LW)) begin : g_bad_depth
         $error("buffer depth must fit the level width");
      end
   endgenerate

   // per-level contexts
   logic [NSLOT-1:0] s_act, s_load, s_adv, s_fin;
   op_e              s_op  [NSLOT];
   logic [CW-1:0]    s_cnt [NSLOT];
   logic [CW-1:0]    s_idx [NSLOT];
   logic [AW-1:0]    s_src [NSLOT];
   logic [AW-1:0]    s_dst [NSLOT];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      mope_slot #(.AW(AW), .CW(CW)) u_slot (
         .clk(clk), .rst_n(rst_n), .load(s_load[g]),
         .load_op(op_e'(cmd_op)), .load_cnt(cmd_count),
         .load_src(cmd_src), .load_dst(cmd_dst),
         .adv(s_adv[g]), .fin(s_fin[g]),
         .active(s_act[g]), .op(s_op[g]), .cnt(s_cnt[g]),
         .src(s_src[g]), .dst(s_dst[g]), .idx(s_idx[g])
      );
   end

   // command intake
   logic src_bad, dst_bad, range_bad, busy, accept, immediate;

   mope_range_chk #(.AW(AW), .CW(CW)) u_src_chk (.base(cmd_src), .len(cmd_count), .over(src_bad));
   mope_range_chk #(.AW(AW), .CW(CW)) u_dst_chk (.base(cmd_dst), .len(cmd_count), .over(dst_bad));

   assign range_bad = src_bad | ((op_e'(cmd_op) != OP_TXAPP) & dst_bad);
   assign busy      = s_act[cmd_prio];
   assign accept    = cmd_valid & ~busy;
   assign immediate = accept & ((cmd_count == '0) | range_bad);

   always_comb begin
      s_load = '0;
      if (accept && !immediate) s_load[cmd_prio] = 1'b1;
   end

   // byte sequencer
   phase_e        phase, ph_nx;
   logic          cur, cur_nx, ps, sel;
   logic [DW-1:0] xor_hold;
   logic          step_done, ovf_now, last;
   op_e           cur_op;
   logic [AW-1:0] src_addr, fwd_dst, rev_dst;

   assign sel      = s_act[1];
   assign ps       = (phase == PH_START) ? sel : cur;
   assign cur_op   = s_op[ps];
   assign last     = (s_idx[ps] == s_cnt[ps] - CW'(1));
   assign src_addr = s_src[ps] + AW'(s_idx[ps]);
   assign fwd_dst  = s_dst[ps] + AW'(s_idx[ps]);
   assign rev_dst  = s_dst[ps] + AW'(CW'(s_cnt[ps] - s_idx[ps] - CW'(1)));

   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = src_addr;
      ram_wdata = ram_rdata;
      txb_we    = 1'b0;
      txb_wdata = ram_rdata;
      s_adv     = '0;
      s_fin     = '0;
      step_done = 1'b0;
      ovf_now   = 1'b0;
      ph_nx     = phase;
      cur_nx    = cur;
      case (phase)
         PH_START: begin
            if (|s_act) begin
               cur_nx = sel;
               if (cur_op == OP_TXAPP && txb_level >= FULL_LVL) begin
                  ovf_now   = 1'b1;
                  s_fin[ps] = 1'b1;
               end else begin
                  ram_en = 1'b1;
                  ph_nx  = PH_SECOND;
               end
            end
         end
         PH_SECOND: begin
            if (cur_op == OP_XOR) begin
               ram_en   = 1'b1;
               ram_addr = fwd_dst;
               ph_nx    = PH_THIRD;
            end else begin
               if (cur_op == OP_TXAPP) begin
                  txb_we = 1'b1;
               end else begin
                  ram_en   = 1'b1;
                  ram_we   = 1'b1;
                  ram_addr = (cur_op == OP_REVCOPY) ? rev_dst : fwd_dst;
               end
               step_done = 1'b1;
               ph_nx     = PH_START;
            end
         end
         PH_THIRD: begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = fwd_dst;
            ram_wdata = ram_rdata ^ xor_hold;
            step_done = 1'b1;
            ph_nx     = PH_START;
         end
         default: ph_nx = PH_START;
      endcase
      if (step_done) begin
         s_adv[ps] = 1'b1;
         if (last) s_fin[ps] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase        <= PH_START;
         cur          <= 1'b0;
         xor_hold     <= '0;
         exc_done_lo  <= 1'b0;
         exc_done_hi  <= 1'b0;
         exc_usage    <= 1'b0;
         exc_addr_err <= 1'b0;
         exc_tx_ovf   <= 1'b0;
         tx_remain    <= '0;
      end else begin
         phase        <= ph_nx;
         cur          <= cur_nx;
         if (phase == PH_SECOND) xor_hold <= ram_rdata;
         exc_done_lo  <= s_fin[0] | (immediate & ~cmd_prio);
         exc_done_hi  <= s_fin[1] | (immediate & cmd_prio);
         exc_usage    <= cmd_valid & busy;
         exc_addr_err <= immediate & range_bad;
         exc_tx_ovf   <= ovf_now;
         if (ovf_now) tx_remain <= s_cnt[ps] - s_idx[ps];
      end
   end
endmodule

// File: rtl/mope_chk.sv
module mope_chk #(
   parameter int LW        = 8,
   parameter int CW        = 8,
   parameter int TXB_DEPTH = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          txb_we,
   input logic [LW-1:0] txb_level,
   input logic          exc_done_lo,
   input logic          exc_done_hi,
   input logic          exc_usage,
   input logic          exc_addr_err,
   input logic          exc_tx_ovf,
   input logic [CW-1:0] tx_remain,
   input logic [1:0]    s_act,
   input logic [1:0]    phase,
   input logic          cur
);
   AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      txb_we |-> (txb_level < LW'(TXB_DEPTH))); // R6
   AST_REMAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_tx_ovf |-> $stable(tx_remain)); // R6
   AST_OVF_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_tx_ovf |-> (exc_done_lo || exc_done_hi)); // R7
   AST_USAGE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      exc_usage |-> $past(cmd_valid)); // R8
   AST_ADDR_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_addr_err |-> ($past(cmd_valid) && (exc_done_lo || exc_done_hi))); // R9
   AST_HIGH_TAKES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd0 && s_act[1]) |=> cur); // R10
endmodule

bind mem_op_engine mope_chk #(.LW(LW), .CW(CW), .TXB_DEPTH(TXB_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .txb_we(txb_we),
   .txb_level(txb_level), .exc_done_lo(exc_done_lo), .exc_done_hi(exc_done_hi),
   .exc_usage(exc_usage), .exc_addr_err(exc_addr_err), .exc_tx_ovf(exc_tx_ovf),
   .tx_remain(tx_remain), .s_act(s_act), .phase(phase), .cur(cur)
);

// File: tb/mem_op_engine_test.sv
`timescale 1ns/1ps
module mem_op_engine_test;
   localparam int DEPTH = 128;
   localparam logic [4:0] M_USE = 5'b10000, M_ADR = 5'b01000, M_OVF = 5'b00100,
                          M_DHI = 5'b00010, M_DLO = 5'b00001;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_prio = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_count = '0;
   logic [11:0] cmd_src = '0, cmd_dst = '0;
   logic ram_en, ram_we, txb_we;
   logic [11:0] ram_addr;
   logic [7:0] ram_wdata, ram_rdata, txb_wdata, tx_remain;
   logic exc_done_lo, exc_done_hi, exc_usage, exc_addr_err, exc_tx_ovf;
   int lvl = 0;
   logic [7:0] txb_level;
   assign txb_level = 8'(lvl);

   always #10 clk = ~clk;

   mem_op_engine uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_prio(cmd_prio), .cmd_count(cmd_count), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .txb_we(txb_we), .txb_wdata(txb_wdata), .txb_level(txb_level),
      .exc_done_lo(exc_done_lo), .exc_done_hi(exc_done_hi), .exc_usage(exc_usage),
      .exc_addr_err(exc_addr_err), .exc_tx_ovf(exc_tx_ovf), .tx_remain(tx_remain)
   );

   int checks = 0, fails = 0, acc = 0;
   bit done_flag = 0;
   logic [7:0] mem  [4096];
   logic [7:0] gold [4096];
   logic [4:0] expq[$];
   string      tagq[$];
   logic [7:0] txq[$];
   logic [7:0] txexp[$];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // RAM model, read latency one cycle
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 7 + 3);
      end else if (ram_en) begin
         acc = acc + 1;
         if (ram_we) mem[ram_addr] <= ram_wdata;
         else        ram_rdata <= mem[ram_addr];
      end
   end

   // transmit buffer model
   always @(posedge clk) begin
      if (rst_n && txb_we) begin
         txq.push_back(txb_wdata);
         lvl = lvl + 1;
      end
   end

   // monitor: compare exception events against the scoreboard
   always @(negedge clk) begin
      logic [4:0] m, e;
      string t;
      if (rst_n) begin
         m = {exc_usage, exc_addr_err, exc_tx_ovf, exc_done_hi, exc_done_lo};
         if (m != 5'b0) begin
            if (expq.size() == 0) check(1'b0, "R7 unexpected event", 32'(m), 32'h0);
            else begin
               e = expq.pop_front();
               t = tagq.pop_front();
               check(m == e, t, 32'(m), 32'(e));
            end
         end
      end
   end

   task automatic expect_ev(input logic [4:0] m, input string tag);
      expq.push_back(m);
      tagq.push_back(tag);
   endtask

   // driver: issue a command and update the reference model
   task automatic issue(input logic [1:0] op, input logic prio, input int cnt,
                        input int src, input int dst, input bit model);
      if (model) begin
         for (int n = 0; n < cnt; n++) begin
            case (op)
               2'd0: if (lvl + txexp.size() < DEPTH) txexp.push_back(gold[src + n]);
               2'd1: gold[dst + n] = gold[src + n];
               2'd2: gold[dst + cnt - 1 - n] = gold[src + n];
               default: gold[dst + n] = gold[dst + n] ^ gold[src + n];
            endcase
         end
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_prio = prio;
      cmd_count = 8'(cnt); cmd_src = 12'(src); cmd_dst = 12'(dst);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int t = 0;
      while (expq.size() != 0 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic check_mem(input string tag);
      int bad = -1;
      for (int i = 0; i < 4096; i++) if (bad < 0 && mem[i] !== gold[i]) bad = i;
      if (bad < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, tag, {12'(bad), 12'h0, mem[bad]}, {12'(bad), 12'h0, gold[bad]});
   endtask

   task automatic check_tx(input string tag);
      check(txq.size() == txexp.size(), tag, 32'(txq.size()), 32'(txexp.size()));
      for (int i = 0; i < txexp.size() && i < txq.size(); i++)
         check(txq[i] == txexp[i], tag, 32'(txq[i]), 32'(txexp[i]));
      txq.delete();
      txexp.delete();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R7 watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int a0;
      for (int i = 0; i < 4096; i++) gold[i] = 8'(i * 7 + 3);
      repeat (4) @(negedge clk);
      // R12 reset state
      check({exc_done_lo, exc_done_hi, exc_usage, exc_addr_err, exc_tx_ovf, ram_en, txb_we} == 7'b0,
            "R12 outputs in reset", {exc_done_lo, exc_done_hi, exc_usage, exc_addr_err, exc_tx_ovf, ram_en, txb_we}, 0);
      check(tx_remain == 8'h0, "R12 tx_remain in reset", 32'(tx_remain), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 forward copy, low level (R1)
      expect_ev(M_DLO, "R1 R2 copy done_lo");
      issue(2'd1, 1'b0, 5, 12'h100, 12'h200, 1);
      wait_idle(); check_mem("R2 copy contents");

      // R3 reverse copy, high level (R1)
      expect_ev(M_DHI, "R1 R3 reverse done_hi");
      issue(2'd2, 1'b1, 6, 12'h300, 12'h400, 1);
      wait_idle(); check_mem("R3 reverse contents");

      // R4 XOR in place; R9 boundary: destination ending exactly at the top
      expect_ev(M_DLO, "R4 xor done_lo");
      issue(2'd3, 1'b0, 4, 12'h500, 12'h600, 1);
      wait_idle(); check_mem("R4 xor contents");
      expect_ev(M_DLO, "R9 xor up to top legal");
      issue(2'd3, 1'b0, 3, 12'hC00, 12'hFFD, 1);
      wait_idle(); check_mem("R9 boundary xor contents");

      // R5 transmit append, destination field ignored
      expect_ev(M_DHI, "R5 append done_hi");
      issue(2'd0, 1'b1, 3, 12'h700, 12'hFFF, 1);
      wait_idle(); check_tx("R5 appended bytes"); check_mem("R5 memory unchanged");
      lvl = 0;

      // R6 overflow: two free places, five bytes asked
      lvl = DEPTH - 2;
      expect_ev(M_OVF | M_DLO, "R6 R7 overflow with done_lo");
      issue(2'd0, 1'b0, 5, 12'h710, 12'h000, 1);
      wait_idle(); check_tx("R6 bytes before full");
      check(tx_remain == 8'd3, "R6 tx_remain", 32'(tx_remain), 3);
      lvl = 0;

      // R8 busy level rejected; R11 zero count on the other level meanwhile
      expect_ev(M_USE, "R8 usage error");
      expect_ev(M_DHI, "R11 zero count done_hi");
      expect_ev(M_DLO, "R8 original op completes");
      issue(2'd1, 1'b0, 40, 12'h900, 12'hA00, 1);
      issue(2'd1, 1'b0, 4, 12'h140, 12'hB40, 0);
      a0 = acc;
      issue(2'd1, 1'b1, 0, 12'h150, 12'hB50, 0);
      wait_idle(); check_mem("R8 running op intact, rejected op silent");

      // R11 zero count alone: no RAM access
      a0 = acc;
      expect_ev(M_DLO, "R11 zero count done_lo");
      issue(2'd2, 1'b0, 0, 12'h160, 12'hB60, 0);
      wait_idle();
      check(acc == a0, "R11 no access", 32'(acc - a0), 0);

      // R9 source past the top: error, done, no access
      a0 = acc;
      expect_ev(M_ADR | M_DHI, "R9 addr error with done_hi");
      issue(2'd1, 1'b1, 4, 12'hFFE, 12'h800, 0);
      wait_idle();
      check(acc == a0, "R9 no access", 32'(acc - a0), 0);
      check_mem("R9 destination untouched");
      expect_ev(M_ADR | M_DLO, "R9 dst past top");
      issue(2'd2, 1'b0, 8, 12'h100, 12'hFFA, 0);
      wait_idle(); check_mem("R9 reverse dst untouched");

      // R10 high op preempts a running low op
      expect_ev(M_DHI, "R10 high finishes first");
      expect_ev(M_DLO, "R10 low finishes after");
      issue(2'd1, 1'b0, 30, 12'hD00, 12'hE00, 1);
      repeat (10) @(negedge clk);
      issue(2'd2, 1'b1, 4, 12'hB00, 12'hB80, 1);
      wait_idle(); check_mem("R10 both results");

      finish_run();
   end
endmodule